// File: doc/BRIEF.md
# Ordered Work Distributor with Reorder Store

This block spreads a single stream of work items over a set of parallel processing units and merges their results back into one stream in the order the items arrived. Every accepted item is given a tag, a small sequence number that counts up in acceptance order and wraps at the reorder depth. The item goes to the unit that currently holds the fewest unfinished items.

Units may finish in any order and at any latency. Each returned result carries its tag and is written into the matching slot of a reorder store. The output stream always presents the slot of the oldest item still in flight, and only once that slot is filled. As a result, the downstream consumer sees results in exact arrival order. This suits any consumer that must process primitives in the order they were submitted.

The number of items in flight is capped at the reorder depth. When that limit is reached, the input stalls. Back-pressure on the output holds back only the release of results. Units keep delivering into their reserved slots while the output waits.

Top module: `seq_dispatch_rob`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, in_ready is 1, no disp_valid bit is set, every unit has zero outstanding items, and the first tag issued is 0.
- R2: Accepted items receive tags 0, 1, …, DEPTH-1, 0, … in acceptance order. The tag appears on disp_tag in the same cycle the item is accepted.
- R3: An accepted item goes to the unit with the fewest outstanding items, where outstanding means dispatched to that unit and not yet returned by it. A tie goes to the lowest unit index. A return in the same cycle as a dispatch takes effect only after that clock edge.
- R4: A disp_valid bit is set only in a cycle where in_valid and in_ready are both high. In such a cycle exactly one bit is set, and disp_data equals in_data. In every other cycle no bit is set.
- R5: in_ready is low exactly when DEPTH items are in flight. An item is in flight from the cycle it is accepted until the cycle its result is released on the output.
- R6: Results leave on the output in the same order their items were accepted, whatever order the units return them in.
- R7: out_valid is high exactly when the oldest in-flight item's result was returned in an earlier cycle. The store adds one cycle of latency.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R9: Results returned while out_ready is low are still captured. The result ports have no ready signal and are sampled in every cycle.
- R10: out_data equals the res_data value that a unit returned with the matching tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can accept an item |
| in_data | input | DATA_W | Input item payload |
| disp_valid | output | NUM_UNITS | One-hot strobe that hands the item to a unit |
| disp_tag | output | TAG_W | Tag of the item being handed out |
| disp_data | output | DATA_W | Payload of the item being handed out |
| res_valid | input | NUM_UNITS | Per-unit result strobe |
| res_tag | input | NUM_UNITS*TAG_W | Per-unit result tag, unit u in bits [u*TAG_W +: TAG_W] |
| res_data | input | NUM_UNITS*DATA_W | Per-unit result payload, unit u in bits [u*DATA_W +: DATA_W] |
| out_valid | output | 1 | Ordered result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | DATA_W | Ordered result payload |

## Verification
Faults surface at the ports at different speeds:

- **Tag counter:** an error shows on disp_tag in the very cycle of the next acceptance.
- **Unit load count:** an error does not show until the next dispatch where that unit would win or lose the comparison, which can be many cycles later. The bench therefore recomputes the minimum on every acceptance.
- **Slot valid bit (lost):** out_valid stays low forever and in_ready falls once DEPTH items pile up behind the hole.
- **Slot valid bit (stale):** the output releases too early or repeats an old result, which is caught at the first release from that slot.
- **Head pointer or in-flight count:** an error disturbs both the release order and the in_ready limit within one pass through the tag range.

// File: rtl/seq_rob_pkg.sv
// Shared constants and helpers for the ordered work distributor.
// Assumes nothing beyond integer parameters being positive.
package seq_rob_pkg;
    localparam int DEF_UNITS  = 4;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_DEPTH  = 8;

    // Width of an index able to name n entries (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rob_unit_select.sv
// Picks the unit with the smallest outstanding-item count.
// Assumes: load_flat packs one CNT_W count per unit, unit 0 in the low bits.
// Strict less-than comparison makes the lowest index win a tie.
module rob_unit_select #(
    parameter int NUM_UNITS = seq_rob_pkg::DEF_UNITS,
    parameter int CNT_W     = 4,
    localparam int IDX_W    = seq_rob_pkg::idx_width(NUM_UNITS)
) (
    input  logic [NUM_UNITS*CNT_W-1:0] load_flat,
    output logic [IDX_W-1:0]           pick
);
    logic [CNT_W-1:0] best_load;

    // Linear scan for the minimum load, earliest index kept on equality.
    always_comb begin
        pick      = '0;
        best_load = load_flat[CNT_W-1:0];
        for (int i = 1; i < NUM_UNITS; i++) begin
            if (load_flat[i*CNT_W +: CNT_W] < best_load) begin
                best_load = load_flat[i*CNT_W +: CNT_W];
                pick      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rob_load_track.sv
// Keeps one outstanding-item counter per unit.
// Assumes: a unit never returns more items than it was given, and the
// total in flight never exceeds the range of CNT_W.
module rob_load_track #(
    parameter int NUM_UNITS = seq_rob_pkg::DEF_UNITS,
    parameter int CNT_W     = 4,
    localparam int IDX_W    = seq_rob_pkg::idx_width(NUM_UNITS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic [IDX_W-1:0]           take_idx,
    input  logic [NUM_UNITS-1:0]       done_vec,
    output logic [NUM_UNITS*CNT_W-1:0] load_flat
);
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt;
        logic             up;

        assign up = take && (take_idx == IDX_W'(g));

        // Count up on dispatch, down on return, hold when both or neither.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (up && !done_vec[g]) begin
                cnt <= cnt + CNT_W'(1);
            end else if (!up && done_vec[g]) begin
                cnt <= cnt - CNT_W'(1);
            end
        end

        assign load_flat[g*CNT_W +: CNT_W] = cnt;
    end
endmodule

// File: rtl/rob_store.sv
// Reorder store: one slot per tag, each with a valid bit.
// Assumes: DEPTH is a power of two, tags returned in the same cycle are
// distinct, and a slot is written only while its valid bit is clear.
module rob_store #(
    parameter int NUM_UNITS = seq_rob_pkg::DEF_UNITS,
    parameter int DEPTH     = seq_rob_pkg::DEF_DEPTH,
    parameter int DATA_W    = seq_rob_pkg::DEF_DATA_W,
    parameter int TAG_W     = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_UNITS-1:0]        wr_en,
    input  logic [NUM_UNITS*TAG_W-1:0]  wr_tag,
    input  logic [NUM_UNITS*DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]            head,
    input  logic                        pop,
    output logic                        head_valid,
    output logic [DATA_W-1:0]           head_data
);
    logic [DEPTH-1:0]  slot_vld;
    logic [DATA_W-1:0] slot_mem [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic              hit;
        logic [DATA_W-1:0] hit_data;
        logic              vld;
        logic [DATA_W-1:0] dat;

        // Find a unit returning this slot's tag in the current cycle.
        always_comb begin
            hit      = 1'b0;
            hit_data = '0;
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (wr_en[u] && (wr_tag[u*TAG_W +: TAG_W] == TAG_W'(s))) begin
                    hit      = 1'b1;
                    hit_data = wr_data[u*DATA_W +: DATA_W];
                end
            end
        end

        // Set on result arrival, clear when released at the head.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= 1'b0;
            end else if (hit) begin
                vld <= 1'b1;
            end else if (pop && (head == TAG_W'(s))) begin
                vld <= 1'b0;
            end
        end

        // Capture the payload of an arriving result.
        always_ff @(posedge clk) begin
            if (hit) begin
                dat <= hit_data;
            end
        end

        assign slot_vld[s] = vld;
        assign slot_mem[s] = dat;
    end

    assign head_valid = slot_vld[head];
    assign head_data  = slot_mem[head];
endmodule

// File: rtl/seq_dispatch_rob.sv
// Ordered work distributor: tags each accepted item, hands it to the
// least loaded unit, and releases results strictly in acceptance order.
// Assumes: DEPTH is a power of two; units accept every dispatch and
// return each item exactly once with its tag; the result ports carry no
// back-pressure.
module seq_dispatch_rob #(
    parameter int NUM_UNITS = seq_rob_pkg::DEF_UNITS,
    parameter int DATA_W    = seq_rob_pkg::DEF_DATA_W,
    parameter int DEPTH     = seq_rob_pkg::DEF_DEPTH,
    localparam int TAG_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int IDX_W    = seq_rob_pkg::idx_width(NUM_UNITS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [DATA_W-1:0]           in_data,
    output logic [NUM_UNITS-1:0]        disp_valid,
    output logic [TAG_W-1:0]            disp_tag,
    output logic [DATA_W-1:0]           disp_data,
    input  logic [NUM_UNITS-1:0]        res_valid,
    input  logic [NUM_UNITS*TAG_W-1:0]  res_tag,
    input  logic [NUM_UNITS*DATA_W-1:0] res_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [DATA_W-1:0]           out_data
);
    logic [TAG_W-1:0]           issue_seq;
    logic [TAG_W-1:0]           head_seq;
    logic [CNT_W-1:0]           inflight;
    logic                       accept;
    logic                       release_now;
    logic [IDX_W-1:0]           pick;
    logic [NUM_UNITS*CNT_W-1:0] load_flat;

    assign in_ready    = (inflight != CNT_W'(DEPTH));
    assign accept      = in_valid && in_ready;
    assign release_now = out_valid && out_ready;
    assign disp_tag    = issue_seq;
    assign disp_data   = in_data;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_disp
        assign disp_valid[g] = accept && (pick == IDX_W'(g));
    end

    rob_load_track #(.NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W)) load_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .take_idx  (pick),
        .done_vec  (res_valid),
        .load_flat (load_flat)
    );

    rob_unit_select #(.NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W)) sel_i (
        .load_flat (load_flat),
        .pick      (pick)
    );

    rob_store #(
        .NUM_UNITS(NUM_UNITS), .DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (res_valid),
        .wr_tag     (res_tag),
        .wr_data    (res_data),
        .head       (head_seq),
        .pop        (release_now),
        .head_valid (out_valid),
        .head_data  (out_data)
    );

    // Advance the issue and head pointers; wrap follows from the power-of-two depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_seq <= '0;
            head_seq  <= '0;
        end else begin
            if (accept)      issue_seq <= issue_seq + TAG_W'(1);
            if (release_now) head_seq  <= head_seq + TAG_W'(1);
        end
    end

    // Track items between acceptance and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else if (accept && !release_now) begin
            inflight <= inflight + CNT_W'(1);
        end else if (!accept && release_now) begin
            inflight <= inflight - CNT_W'(1);
        end
    end
endmodule

// File: rtl/seq_rob_chk.sv
// Property checker for seq_dispatch_rob, attached with bind.
// Keeps its own acceptance and release counts from the port handshakes.
module seq_rob_chk #(
    parameter int NUM_UNITS = 4,
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 8,
    parameter int TAG_W     = 3,
    parameter int CNT_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [NUM_UNITS-1:0] disp_valid,
    input logic [TAG_W-1:0]     disp_tag,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [DATA_W-1:0]    out_data
);
    logic [TAG_W-1:0] seen_tag;
    logic [CNT_W-1:0] seen_infl;
    logic             acc_hs;
    logic             rel_hs;

    assign acc_hs = in_valid && in_ready;
    assign rel_hs = out_valid && out_ready;

    // Independent copy of the expected tag and in-flight count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_tag  <= '0;
            seen_infl <= '0;
        end else begin
            if (acc_hs) seen_tag <= seen_tag + TAG_W'(1);
            if (acc_hs && !rel_hs)      seen_infl <= seen_infl + CNT_W'(1);
            else if (!acc_hs && rel_hs) seen_infl <= seen_infl - CNT_W'(1);
        end
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    // R2
    tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hs |-> (disp_tag == seen_tag));

    // R4
    one_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hs |-> ($countones(disp_valid) == 1));

    // R4
    idle_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hs |-> (disp_valid == '0));

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_infl == CNT_W'(DEPTH)) |-> !in_ready);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind seq_dispatch_rob seq_rob_chk #(
    .NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .TAG_W(TAG_W), .CNT_W(CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .disp_valid (disp_valid),
    .disp_tag   (disp_tag),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
);

// File: tb/seq_dispatch_rob_tb_top.sv
// Scoreboard bench: units are modelled with random latency and random
// pick order; expected outputs come from a queue filled at acceptance.
module seq_dispatch_rob_tb_top;
    localparam int NU  = 4;
    localparam int DW  = 16;
    localparam int DEP = 8;
    localparam int TW  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DW-1:0]     in_data = '0;
    logic [NU-1:0]     disp_valid;
    logic [TW-1:0]     disp_tag;
    logic [DW-1:0]     disp_data;
    logic [NU-1:0]     res_valid = '0;
    logic [NU*TW-1:0]  res_tag = '0;
    logic [NU*DW-1:0]  res_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DW-1:0]     out_data;

    always #4 clk = ~clk;

    seq_dispatch_rob #(.NUM_UNITS(NU), .DATA_W(DW), .DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_data(disp_data),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;
    int load_m [NU];
    int infl_m = 0;
    int issue_m = 0;
    int head_m = 0;
    bit ret_m [DEP];
    logic [DW-1:0]    sb [$];
    logic [TW+DW-1:0] uq [NU][$];
    logic [DW-1:0]    next_data = 16'h1000;
    int  in_pct = 0, ret_pct = 0, rdy_pct = 0;
    bit  hold_pend = 1'b0;
    logic [DW-1:0] hold_data = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_pick();
        int best = 0;
        for (int i = 1; i < NU; i++) if (load_m[i] < load_m[best]) best = i;
        return best;
    endfunction

    // One cycle: drive at negedge, settle, check and update the model.
    task automatic step();
        bit  pres [NU];
        int  ptag [NU];
        bit  exp_ov;
        int  best;
        int  idx;
        logic [TW+DW-1:0] item;
        @(negedge clk);
        in_valid  = (($urandom % 100) < in_pct);
        in_data   = next_data;
        out_ready = (($urandom % 100) < rdy_pct);
        for (int u = 0; u < NU; u++) begin
            pres[u] = 1'b0;
            ptag[u] = 0;
            res_valid[u] = 1'b0;
            if (uq[u].size() > 0 && (($urandom % 100) < ret_pct)) begin
                idx  = int'($urandom % uq[u].size());
                item = uq[u][idx];
                uq[u].delete(idx);
                res_valid[u] = 1'b1;
                res_tag[u*TW +: TW]  = item[TW+DW-1:DW];
                res_data[u*DW +: DW] = item[DW-1:0];
                pres[u] = 1'b1;
                ptag[u] = int'(item[TW+DW-1:DW]);
            end
        end
        #1;
        if (hold_pend) begin
            // R8: stalled output keeps its item
            chk(out_valid && out_data == hold_data, "R8", out_data, hold_data);
        end
        exp_ov = (infl_m > 0) && ret_m[head_m];
        // R7 (R9 when the output is stalled): head visibility
        chk(out_valid == exp_ov, out_ready ? "R7" : "R9", out_valid, exp_ov);
        // R5: in_ready tracks the in-flight limit
        chk(in_ready == (infl_m < DEP), "R5", in_ready, infl_m < DEP);
        best = model_pick();
        if (in_valid && in_ready) begin
            // R3 and R4: one strobe, to the least loaded unit
            chk(disp_valid == NU'(1 << best), "R3", disp_valid, 1 << best);
            // R2: tag sequence
            chk(disp_tag == TW'(issue_m), "R2", disp_tag, issue_m);
            chk(disp_data == in_data, "R4", disp_data, in_data);
            uq[best].push_back({TW'(issue_m), in_data});
            sb.push_back(in_data);
            load_m[best]++;
            issue_m = (issue_m + 1) % DEP;
            next_data = next_data + 16'd7;
        end else begin
            chk(disp_valid == '0, "R4", disp_valid, 0);
        end
        if (out_valid && out_ready) begin
            // R6 and R10: order and payload
            if (sb.size() == 0) chk(1'b0, "R6", out_data, -1);
            else chk(out_data == sb[0], "R6/R10", out_data, sb[0]);
            if (sb.size() > 0) void'(sb.pop_front());
            ret_m[head_m] = 1'b0;
            head_m = (head_m + 1) % DEP;
        end
        if (in_valid && in_ready) infl_m++;
        if (out_valid && out_ready) infl_m--;
        for (int u = 0; u < NU; u++) begin
            if (pres[u]) begin
                load_m[u]--;
                ret_m[ptag[u]] = 1'b1;
            end
        end
        hold_pend = out_valid && !out_ready;
        hold_data = out_data;
    endtask

    task automatic run(input int n, input int ip, input int rp, input int op);
        in_pct = ip; ret_pct = rp; rdy_pct = op;
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        for (int u = 0; u < NU; u++) load_m[u] = 0;
        for (int t = 0; t < DEP; t++) ret_m[t] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        chk(disp_valid == '0, "R1", disp_valid, 0);
        // Ties: no returns, loads equal, units filled in index order; then full.
        run(12, 100, 0, 100);
        // Mixed random traffic.
        run(3000, 60, 30, 70);
        // Output stalled while units keep returning.
        run(300, 100, 50, 0);
        // Heavy traffic.
        run(2000, 90, 80, 90);
        // Drain.
        in_pct = 0; ret_pct = 100; rdy_pct = 100;
        for (int k = 0; k < 500 && (sb.size() > 0); k++) step();
        chk(sb.size() == 0, "R6", sb.size(), 0);
        chk(in_ready == 1'b1, "R5", in_ready, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule